// File: doc/BRIEF.md
# Up/Down Spanning-Tree Route Selector

This unit computes the output port for one switch of a 16-switch irregular network-on-chip. Every switch sits in a breadth-first spanning tree rooted at node 0. Each switch has a tree address that spells out its path from the root. Besides the tree links, some switches also have wireline or wireless shortcut links. Each switch holds its own instance of the unit. The node identity is a parameter, so the switch's own address, its children, its shortcuts and its table of upward choices are all fixed at elaboration.

A request carries a destination tree address and a one-bit phase. Phase 0 means the packet has only climbed so far; phase 1 means it has already taken a downward tree link. One clock later the unit returns four things:
- the chosen port;
- the class of link that port uses;
- the phase the packet carries onward;
- an error flag.

Routes always climb first and descend afterwards. Climbing uses the parent link or a shortcut, and every shortcut counts as a climb. Once a packet descends it never climbs again, which keeps the irregular network free of routing cycles.

Top module: `tree_route_unit`

## Requirements
- R1: While rst_ni is low, and after it rises until the first request, outputs are: valid_o=0, port_o=0, kind_o=0, phase_o=0, err_o=0.
- R2: A request is taken on a rising clock edge with valid_i=1, and its result appears on the outputs after that edge with valid_o=1. After an edge with valid_i=0, valid_o is 0 and port_o, kind_o, phase_o and err_o keep their previous values.
- R3: If dst_addr_i equals the node's own address, the result is port_o=0 (local ejection) and kind_o=0, and phase_o equals phase_i.
- R4: Address encoding:
  - An address is three 2-bit digits. The first tree level is in bits 5:4 and the third is in bits 1:0.
  - Each digit is the child's rank among its siblings, counted 1..3 in ascending node id. A digit of 0 means no further level. The root's address is 0.
  - If the destination lies strictly inside the node's subtree (own address is a digit prefix of it), the result is port_o = 2 + (next digit - 1), kind_o=2 (tree down) and phase_o=1, in either phase.
- R5: The tree's parents for nodes 0..15 are 0,0,0,0,1,1,2,2,3,3,4,4,6,6,8,8.
  - In phase 0, a destination outside the subtree selects the shortcut slot whose far node is deepest among those whose subtree contains the destination.
  - If no such shortcut exists, the result is the parent link: port_o=1, kind_o=1.
  - phase_o is 0 in both cases.
- R6: Shortcut edges, in this order, are: 5-7, 10-9, 11-12, 13-3 and 4-9 (wireline), and 4-15, 2-14 and 1-6 (wireless).
  - A node's shortcut slots are numbered 0,1 in edge order, and slot s uses port 5+s.
  - kind_o is 3 for a wireline shortcut and 4 for a wireless one.
- R7: In phase 1, a valid destination that is neither the node itself nor inside its subtree gives err_o=1, port_o=0, kind_o=0 and phase_o=1. No upward port is chosen.
- R8: A dst_addr_i that matches no node's address gives err_o=1, port_o=0, kind_o=0.
- R9: Following the selected ports from any source to any destination, starting in phase 0, reaches the destination within 7 hops. No route takes a parent or shortcut link after a down link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| phase_i | input | 1 | Packet phase: 0 climbing, 1 descending |
| dst_addr_i | input | 6 | Destination tree address |
| valid_o | output | 1 | Result registered from a request |
| port_o | output | 3 | Selected port: 0 local, 1 parent, 2-4 child, 5-6 shortcut |
| kind_o | output | 3 | Link class: 0 local, 1 tree up, 2 tree down, 3 wireline, 4 wireless |
| phase_o | output | 1 | Phase the packet leaves with |
| err_o | output | 1 | Illegal phase or unknown address |

## Verification
A faulty digit offset, subtree mask or up-table entry shows on the cycle after the request, as a wrong port_o or kind_o for that source and destination. Walking every pair hop by hop turns such a slip into a visible symptom within at most 7 steps: a route that turns up after going down, lands on a non-existent neighbour, or fails to end at its destination. A phase that is dropped or inverted shows as a missing err_o on the descending path, or as a parent or shortcut selection after a descent.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;

  localparam int NODES     = 16;
  localparam int ID_W      = $clog2(NODES);
  localparam int ROOT      = 0;
  localparam int MAX_DEPTH = 3;
  localparam int MAX_KIDS  = 3;
  localparam int DIG_W     = $clog2(MAX_KIDS + 1);
  localparam int ADDR_W    = MAX_DEPTH * DIG_W;
  localparam int MAX_SC    = 2;
  localparam int SC_EDGES  = 8;

  localparam int PORT_LOCAL  = 0;
  localparam int PORT_PARENT = 1;
  localparam int PORT_CHILD0 = 2;
  localparam int PORT_SC0    = PORT_CHILD0 + MAX_KIDS;
  localparam int NUM_PORTS   = PORT_SC0 + MAX_SC;
  localparam int PORT_W      = $clog2(NUM_PORTS);

  localparam logic PH_UP   = 1'b0;
  localparam logic PH_DOWN = 1'b1;

  typedef enum logic [2:0] {
    LK_LOCAL     = 3'd0,
    LK_TREE_UP   = 3'd1,
    LK_TREE_DOWN = 3'd2,
    LK_WIRE      = 3'd3,
    LK_RADIO     = 3'd4
  } link_kind_e;

  typedef logic [NODES-1:0][PORT_W-1:0] up_tbl_t;
  typedef logic [MAX_SC-1:0][2:0]       sc_kind_t;

  // breadth-first tree; the root points at itself
  localparam int PARENT [NODES] = '{0, 0, 0, 0, 1, 1, 2, 2, 3, 3, 4, 4, 6, 6, 8, 8};

  localparam int SC_A     [SC_EDGES] = '{5, 10, 11, 13, 4, 4, 2, 1};
  localparam int SC_B     [SC_EDGES] = '{7,  9, 12,  3, 9, 15, 14, 6};
  localparam bit SC_RADIO [SC_EDGES] = '{0,  0,  0,  0, 0, 1, 1, 1};

  function automatic int depth_of(int n);
    int d;
    int cur;
    d   = 0;
    cur = n;
    for (int k = 0; k < NODES; k++) begin
      if (cur != ROOT) begin
        d++;
        cur = PARENT[cur];
      end
    end
    return d;
  endfunction

  function automatic int kid_rank(int n);
    int r;
    r = 1;
    for (int m = 0; m < NODES; m++)
      if (m != ROOT && m < n && PARENT[m] == PARENT[n]) r++;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_of(int n);
    logic [ADDR_W-1:0] a;
    int cur;
    int d;
    a   = '0;
    cur = n;
    d   = depth_of(n);
    for (int l = MAX_DEPTH; l >= 1; l--) begin
      if (l <= d) begin
        a[(MAX_DEPTH-l)*DIG_W +: DIG_W] = DIG_W'(kid_rank(cur));
        cur = PARENT[cur];
      end
    end
    return a;
  endfunction

  function automatic logic [ADDR_W-1:0] prefix_mask(int d);
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int l = 1; l <= MAX_DEPTH; l++)
      if (l <= d) m[(MAX_DEPTH-l)*DIG_W +: DIG_W] = '1;
    return m;
  endfunction

  function automatic bit in_subtree(int top, int n);
    bit hit;
    int cur;
    hit = 1'b0;
    cur = n;
    for (int k = 0; k <= NODES; k++) begin
      if (cur == top) hit = 1'b1;
      cur = PARENT[cur];
    end
    return hit;
  endfunction

  function automatic int sc_nbr(int n, int slot);
    int nb;
    int cnt;
    nb  = -1;
    cnt = 0;
    for (int e = 0; e < SC_EDGES; e++) begin
      if (SC_A[e] == n || SC_B[e] == n) begin
        if (cnt == slot) nb = (SC_A[e] == n) ? SC_B[e] : SC_A[e];
        cnt++;
      end
    end
    return nb;
  endfunction

  function automatic sc_kind_t sc_kinds(int n);
    sc_kind_t k;
    int cnt;
    k   = '0;
    cnt = 0;
    for (int e = 0; e < SC_EDGES; e++) begin
      if ((SC_A[e] == n || SC_B[e] == n) && cnt < MAX_SC) begin
        k[cnt] = SC_RADIO[e] ? LK_RADIO : LK_WIRE;
        cnt++;
      end
    end
    return k;
  endfunction

  // climbing choice per destination: deepest shortcut whose subtree holds it, else parent
  function automatic up_tbl_t build_up_tbl(int n);
    up_tbl_t t;
    int best;
    int port;
    int nb;
    for (int d = 0; d < NODES; d++) begin
      best = -1;
      port = PORT_PARENT;
      for (int s = 0; s < MAX_SC; s++) begin
        nb = sc_nbr(n, s);
        if (nb >= 0 && in_subtree(nb, d) && depth_of(nb) > best) begin
          best = depth_of(nb);
          port = PORT_SC0 + s;
        end
      end
      t[d] = PORT_W'(port);
    end
    return t;
  endfunction

endpackage

// File: rtl/tr_addr_decode.sv
module tr_addr_decode
  import tree_route_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ID_W-1:0]   id_o
);

  logic [NODES-1:0] match;

  for (genvar n = 0; n < NODES; n++) begin : g_cmp
    localparam logic [ADDR_W-1:0] NODE_ADDR = addr_of(n);
    assign match[n] = (addr_i == NODE_ADDR);
  end

  always_comb begin
    id_o = '0;
    for (int n = 0; n < NODES; n++)
      if (match[n]) id_o = ID_W'(n);
  end

  assign hit_o = |match;

endmodule

// File: rtl/tr_down_pick.sv
module tr_down_pick
  import tree_route_pkg::*;
#(
  parameter int NODE_ID = 0
) (
  input  logic [ADDR_W-1:0] dst_i,
  output logic              at_self_o,
  output logic              in_sub_o,
  output logic [PORT_W-1:0] port_o
);

  localparam int                DEPTH = depth_of(NODE_ID);
  localparam logic [ADDR_W-1:0] SELF  = addr_of(NODE_ID);
  localparam logic [ADDR_W-1:0] MASK  = prefix_mask(DEPTH);

  assign at_self_o = (dst_i == SELF);
  assign in_sub_o  = ((dst_i ^ SELF) & MASK) == '0;

  if (DEPTH < MAX_DEPTH) begin : g_inner
    logic [DIG_W-1:0] dig;
    assign dig    = dst_i[(MAX_DEPTH-DEPTH-1)*DIG_W +: DIG_W];
    assign port_o = PORT_W'(PORT_CHILD0) + PORT_W'(dig) - PORT_W'(1);
  end else begin : g_leaf
    assign port_o = PORT_W'(PORT_LOCAL);
  end

endmodule

// File: rtl/tr_up_pick.sv
module tr_up_pick
  import tree_route_pkg::*;
#(
  parameter int      NODE_ID = 0,
  parameter up_tbl_t UP_TBL  = build_up_tbl(NODE_ID)
) (
  input  logic [ID_W-1:0]   dst_id_i,
  output logic [PORT_W-1:0] port_o,
  output link_kind_e        kind_o
);

  localparam sc_kind_t SC_KIND = sc_kinds(NODE_ID);

  always_comb begin
    port_o = UP_TBL[dst_id_i];
    kind_o = LK_TREE_UP;
    for (int s = 0; s < MAX_SC; s++)
      if (port_o == PORT_W'(PORT_SC0 + s)) kind_o = link_kind_e'(SC_KIND[s]);
  end

endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
  import tree_route_pkg::*;
#(
  parameter int      NODE_ID = 0,
  parameter up_tbl_t UP_TBL  = build_up_tbl(NODE_ID)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              phase_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  output logic              valid_o,
  output logic [PORT_W-1:0] port_o,
  output logic [2:0]        kind_o,
  output logic              phase_o,
  output logic              err_o
);

  logic              hit;
  logic [ID_W-1:0]   dst_id;
  logic              at_self;
  logic              in_sub;
  logic [PORT_W-1:0] down_port;
  logic [PORT_W-1:0] up_port;
  link_kind_e        up_kind;

  logic [PORT_W-1:0] nxt_port;
  link_kind_e        nxt_kind;
  logic              nxt_phase;
  logic              nxt_err;

  tr_addr_decode u_decode (
    .addr_i (dst_addr_i),
    .hit_o  (hit),
    .id_o   (dst_id)
  );

  tr_down_pick #(.NODE_ID(NODE_ID)) u_down (
    .dst_i     (dst_addr_i),
    .at_self_o (at_self),
    .in_sub_o  (in_sub),
    .port_o    (down_port)
  );

  tr_up_pick #(.NODE_ID(NODE_ID), .UP_TBL(UP_TBL)) u_up (
    .dst_id_i (dst_id),
    .port_o   (up_port),
    .kind_o   (up_kind)
  );

  always_comb begin
    nxt_port  = PORT_W'(PORT_LOCAL);
    nxt_kind  = LK_LOCAL;
    nxt_phase = phase_i;
    nxt_err   = 1'b0;
    if (!hit) begin
      nxt_err = 1'b1;
    end else if (at_self) begin
      nxt_port = PORT_W'(PORT_LOCAL);
    end else if (in_sub) begin
      nxt_port  = down_port;
      nxt_kind  = LK_TREE_DOWN;
      nxt_phase = PH_DOWN;
    end else if (phase_i == PH_DOWN) begin
      // climbing after a descent is never allowed
      nxt_err = 1'b1;
    end else begin
      nxt_port  = up_port;
      nxt_kind  = up_kind;
      nxt_phase = PH_UP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      port_o  <= '0;
      kind_o  <= LK_LOCAL;
      phase_o <= PH_UP;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        port_o  <= nxt_port;
        kind_o  <= nxt_kind;
        phase_o <= nxt_phase;
        err_o   <= nxt_err;
      end
    end
  end

endmodule

// File: rtl/tree_route_chk.sv
module tree_route_chk
  import tree_route_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              phase_i,
  input logic              valid_o,
  input logic [PORT_W-1:0] port_o,
  input logic [2:0]        kind_o,
  input logic              phase_o,
  input logic              err_o
);

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(port_o) && $stable(kind_o) && $stable(phase_o) && $stable(err_o)));

  // R3
  local_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o && kind_o == LK_LOCAL) |-> port_o == PORT_W'(PORT_LOCAL));

  // R4
  down_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && kind_o == LK_TREE_DOWN) |->
      (phase_o == PH_DOWN && port_o >= PORT_W'(PORT_CHILD0) && port_o < PORT_W'(PORT_SC0)));

  // R5
  parent_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && kind_o == LK_TREE_UP) |-> (port_o == PORT_W'(PORT_PARENT) && phase_o == PH_UP));

  // R6
  shortcut_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (kind_o == LK_WIRE || kind_o == LK_RADIO)) |->
      (port_o >= PORT_W'(PORT_SC0) && phase_o == PH_UP));

  // R7
  err_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> (port_o == PORT_W'(PORT_LOCAL) && kind_o == LK_LOCAL));

  // R9
  no_up_after_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && phase_i == PH_DOWN) |=>
      (phase_o == PH_DOWN && (kind_o == LK_LOCAL || kind_o == LK_TREE_DOWN)));

endmodule

bind tree_route_unit tree_route_chk u_chk (.*);

// File: tb/tree_route_unit_tb.sv
`timescale 1ns/1ps
module tree_route_unit_tb;
  import tree_route_pkg::ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic phase = 1'b0;
  logic [ADDR_W-1:0] dst = '0;

  logic       vo  [16];
  logic [2:0] po  [16];
  logic [2:0] ko  [16];
  logic       pho [16];
  logic       eo  [16];

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  for (genvar n = 0; n < 16; n++) begin : g_node
    tree_route_unit #(.NODE_ID(n)) u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .valid_i    (valid),
      .phase_i    (phase),
      .dst_addr_i (dst),
      .valid_o    (vo[n]),
      .port_o     (po[n]),
      .kind_o     (ko[n]),
      .phase_o    (pho[n]),
      .err_o      (eo[n])
    );
  end

  // independent network description
  int par [16] = '{0, 0, 0, 0, 1, 1, 2, 2, 3, 3, 4, 4, 6, 6, 8, 8};
  logic [5:0] adr [16] = '{6'b000000, 6'b010000, 6'b100000, 6'b110000,
                           6'b010100, 6'b011000, 6'b100100, 6'b101000,
                           6'b110100, 6'b111000, 6'b010101, 6'b010110,
                           6'b100101, 6'b100110, 6'b110101, 6'b110110};
  int sca [8] = '{5, 10, 11, 13, 4, 4, 2, 1};
  int scb [8] = '{7,  9, 12,  3, 9, 15, 14, 6};
  bit scr [8] = '{0,  0,  0,  0, 0, 1, 1, 1};

  function automatic bit in_sub(int top, int n);
    int cur = n;
    bit h = 0;
    for (int k = 0; k < 17; k++) begin
      if (cur == top) h = 1;
      cur = par[cur];
    end
    return h;
  endfunction

  function automatic int depth(int n);
    int cur = n;
    int d = 0;
    while (cur != 0) begin
      d++;
      cur = par[cur];
    end
    return d;
  endfunction

  function automatic int nbr_slot(int n, int s, output bit radio);
    int c = 0;
    int nb = -1;
    radio = 0;
    for (int e = 0; e < 8; e++) begin
      if (sca[e] == n || scb[e] == n) begin
        if (c == s) begin
          nb = (sca[e] == n) ? scb[e] : sca[e];
          radio = scr[e];
        end
        c++;
      end
    end
    return nb;
  endfunction

  function automatic int rank(int c);
    int r = 1;
    for (int m = 1; m < c; m++) if (par[m] == par[c]) r++;
    return r;
  endfunction

  function automatic int find_id(logic [5:0] a);
    int id = -1;
    for (int n = 0; n < 16; n++) if (adr[n] == a) id = n;
    return id;
  endfunction

  function automatic int child_toward(int n, int d);
    int cur = d;
    int c = -1;
    for (int k = 0; k < 16; k++) begin
      if (cur != 0 && par[cur] == n) c = cur;
      cur = par[cur];
    end
    return c;
  endfunction

  function automatic int next_node(int cur, int port);
    bit r;
    int nb = -1;
    if (port == 1) nb = (cur == 0) ? -1 : par[cur];
    else if (port >= 2 && port <= 4) begin
      for (int m = 1; m < 16; m++) if (par[m] == cur && rank(m) == port - 1) nb = m;
    end else if (port >= 5 && port <= 6) nb = nbr_slot(cur, port - 5, r);
    return nb;
  endfunction

  task automatic model(input int cur, input logic [5:0] a, input logic ph,
                       output int e_port, output int e_kind, output logic e_ph,
                       output logic e_err, output string tag);
    int d = find_id(a);
    int best = -1;
    bit r;
    int nb;
    e_port = 0; e_kind = 0; e_ph = ph; e_err = 0;
    if (d < 0) begin
      e_err = 1; tag = "R8";
    end else if (d == cur) begin
      tag = "R3";
    end else if (in_sub(cur, d)) begin
      e_port = 1 + rank(child_toward(cur, d)); e_kind = 2; e_ph = 1; tag = "R4";
    end else if (ph) begin
      e_err = 1; tag = "R7";
    end else begin
      e_port = 1; e_kind = 1; e_ph = 0; tag = "R5";
      for (int s = 0; s < 2; s++) begin
        nb = nbr_slot(cur, s, r);
        if (nb >= 0 && in_sub(nb, d) && depth(nb) > best) begin
          best = depth(nb); e_port = 5 + s; e_kind = r ? 4 : 3; tag = "R6";
        end
      end
    end
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input int cur, input logic [5:0] a, input logic ph);
    int e_port, e_kind;
    logic e_ph, e_err;
    string tag;
    valid = 1; phase = ph; dst = a;
    @(posedge clk);
    @(negedge clk);
    valid = 0;
    model(cur, a, ph, e_port, e_kind, e_ph, e_err, tag);
    check("R2", "valid_o", int'(vo[cur]), 1);
    check(tag, "port_o", int'(po[cur]), e_port);
    check(tag, "kind_o", int'(ko[cur]), e_kind);
    check(tag, "phase_o", int'(pho[cur]), int'(e_ph));
    check(tag, "err_o", int'(eo[cur]), int'(e_err));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog (R9): actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cur, hops, nb;
    bit went_down;
    repeat (3) @(negedge clk);
    // R1 reset state on every node
    for (int n = 0; n < 16; n++) begin
      check("R1", "valid_o", int'(vo[n]), 0);
      check("R1", "port_o", int'(po[n]), 0);
      check("R1", "kind_o", int'(ko[n]), 0);
      check("R1", "phase_o", int'(pho[n]), 0);
      check("R1", "err_o", int'(eo[n]), 0);
    end
    rst_n = 1;
    @(negedge clk);
    check("R1", "valid_o after release", int'(vo[5]), 0);

    // R2 hold while idle
    apply(10, adr[14], 0);
    dst = adr[10]; phase = 1;
    @(negedge clk);
    check("R2", "idle valid_o", int'(vo[10]), 0);
    check("R2", "idle port_o", int'(po[10]), 1);
    check("R2", "idle kind_o", int'(ko[10]), 1);
    check("R2", "idle phase_o", int'(pho[10]), 0);

    // R7 illegal climb in down phase
    apply(4, adr[2], 1);
    apply(13, adr[0], 1);
    apply(15, adr[14], 1);
    // R8 addresses that name no node
    apply(0, 6'b000001, 0);
    apply(4, 6'b011100, 0);
    apply(3, 6'b111100, 1);
    apply(8, 6'b110111, 0);
    // R6 shortcut picks
    apply(4, adr[9], 0);
    apply(4, adr[15], 0);
    apply(2, adr[14], 0);
    apply(13, adr[3], 0);
    // R4 down in either phase
    apply(0, adr[15], 1);
    apply(1, adr[11], 0);

    // R9 full walk of every pair
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 16; d++) begin
        cur = s; hops = 0; went_down = 0; phase = 0;
        while (cur != d && hops <= 7) begin
          apply(cur, adr[d], went_down);
          if (went_down && (ko[cur] == 1 || ko[cur] == 3 || ko[cur] == 4)) begin
            n_bad++;
            $display("FAIL R9 up after down %0d->%0d at %0d: actual kind=%0d expected=2", s, d, cur, ko[cur]);
          end
          if (ko[cur] == 2) went_down = 1;
          nb = next_node(cur, int'(po[cur]));
          if (nb < 0 || eo[cur]) begin
            n_bad++;
            $display("FAIL R9 dead end %0d->%0d at %0d: actual port=%0d expected=valid link", s, d, cur, po[cur]);
            break;
          end
          cur = nb;
          hops++;
        end
        check("R9", "hops within bound", (hops <= 7) ? 1 : 0, 1);
        if (cur == d) apply(cur, adr[d], went_down);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule